// File: doc/BRIEF.md
# Iterative Minifloat Divider and Square Root

This unit takes two operands in an 8-bit minifloat format and returns either their quotient or the square root of the first operand. The format has one sign bit (bit 7), a 3-bit exponent field (bits 6:4) with a bias of 3, and a 4-bit fraction (bits 3:0) behind an implied leading one. A word whose exponent field is 0 is a zero, whatever its fraction bits hold. There are no subnormals, infinities or NaNs.

A caller raises `start` for one cycle with `op_sqrt`, `a` and `b`. One shared radix-2 restoring shift-subtract engine then produces one significand bit per clock. For division the exponents are subtracted. For square root the unbiased exponent is halved; when it is odd, the significand is doubled first. The raw bits are normalized and rounded to nearest with guard, round and sticky bits, then packed. `done` pulses for one cycle when `result` is ready. Zero and invalid operands are resolved at once, without running the loop.

Top module: `mf_divsqrt`

## Requirements
- R1: An operand whose exponent field (bits 6:4) is 0 is treated as a signed zero, regardless of its fraction bits.
- R2: With `op_sqrt`=0 and both operands non-zero, `result` is the quotient a/b rounded to nearest. Its sign bit is the XOR of the operand signs, and its exponent field is ea-eb+3, less one when the significand quotient is below 1.
- R3: With `op_sqrt`=1 and a positive non-zero `a`, `result` is the square root rounded to nearest. The unbiased exponent is halved, and an odd exponent is first made even by doubling the significand. The sign bit is 0.
- R4: Rounding uses the guard, round and sticky bits below the 4 kept fraction bits. The result rounds up when the guard bit is set and the round bit, the sticky bit or the kept LSB is set.
- R5: A result whose exponent would exceed 7 saturates to the largest magnitude (bits 6:0 all ones) and keeps its sign.
- R6: A result whose exponent would fall below 1 is flushed to zero and keeps its sign.
- R7: A zero divisor returns 8'hFF, even when the dividend is also zero. The square root of a negative non-zero operand also returns 8'hFF.
- R8: A zero dividend with a non-zero divisor returns zero with the XOR sign. The square root of a zero returns that same zero.
- R9: For operands that need the loop, `busy` is high from the edge that accepts `start` until `done` rises, 9 edges later (QW+1 with QW=8 quotient bits). For the cases of R1, R7 and R8, `done` rises on the accepting edge itself and `busy` stays low.
- R10: `start` is ignored while `busy` is high. Neither the result nor the timing of the running operation changes, and no extra `done` follows.
- R11: `done` is high for exactly one cycle. `result` holds its value until a later operation completes.
- R12: While `rst_n` is low, `busy`, `done` and `result` are all 0, even if an operation was running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to begin an operation |
| op_sqrt | input | 1 | 0 divides a by b, 1 takes the square root of a |
| a | input | 8 | Dividend or radicand |
| b | input | 8 | Divisor, unused for square root |
| busy | output | 1 | The iteration loop is running |
| done | output | 1 | One-cycle pulse when result is updated |
| result | output | 8 | Packed minifloat result |

## Verification
The hardest situation to reach from the ports is a second request that arrives while the loop is part way through. It must not disturb the partial quotient, the held exponent or the cycle count. The bench starts a division and pulses `start` again with a square-root request a few cycles later. It then checks the first result, the original latency, and the absence of any further `done`. Odd negative unbiased exponents need the arithmetic shift in the exponent-halving path, so the stimulus includes radicands of 0.5 and 0.25, and also an operand with a zero exponent field but non-zero fraction bits.

// File: rtl/mf_pkg.sv
// Shared sizes for the minifloat divide/square-root unit.
// Assumes a sign | exponent | fraction layout with an implied leading one.
package mf_pkg;
    localparam int EW   = 3;                // exponent field width
    localparam int MW   = 4;                // stored fraction width
    localparam int W    = 1 + EW + MW;      // packed word width
    localparam int BIAS = 3;                // exponent bias
    localparam int SIGW = MW + 1;           // significand with hidden one
    localparam int QW   = MW + 4;           // raw quotient/root bits
    localparam int RW   = QW + 3;           // partial remainder width
    localparam int NW   = 2 * QW;           // square-root radicand width
    localparam int EXW  = EW + 3;           // signed working exponent width
    localparam int MAXE = (1 << EW) - 1;    // largest exponent field value
    localparam int CW   = $clog2(QW + 1);   // iteration counter width

    typedef logic [W-1:0] word_t;
endpackage

// File: rtl/mf_iter_core.sv
// Radix-2 restoring engine shared by divide and square root.
// One result bit per step. Divide: sig_a is the dividend significand and
// sig_b the divisor. Square root: sig_a is the (possibly doubled) radicand.
// Assumes load and step are never high together.
module mf_iter_core
    import mf_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            step,
    input  logic            op_sqrt,
    input  logic [SIGW:0]   sig_a,
    input  logic [SIGW-1:0] sig_b,
    output logic [QW-1:0]   q,
    output logic            rem_nz
);
    logic            op_q;
    logic [RW-1:0]   rem_q;
    logic [NW-1:0]   rad_q;
    logic [SIGW-1:0] dvs_q;
    logic [QW-1:0]   q_q;
    logic [RW-1:0]   cur, trial, diff, kept;
    logic            ge;

    // Form the trial subtraction for the current step.
    always_comb begin
        if (op_q) begin
            cur   = {rem_q[RW-3:0], rad_q[NW-1 -: 2]};
            trial = RW'({q_q, 2'b01});
        end else begin
            cur   = rem_q;
            trial = RW'(dvs_q);
        end
        ge   = (cur >= trial);
        diff = cur - trial;
        kept = ge ? diff : cur;
    end

    // Load operands, then shift in one result bit per step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q  <= 1'b0;
            rem_q <= '0;
            rad_q <= '0;
            dvs_q <= '0;
            q_q   <= '0;
        end else if (load) begin
            op_q  <= op_sqrt;
            q_q   <= '0;
            dvs_q <= sig_b;
            if (op_sqrt) begin
                rem_q <= '0;
                rad_q <= {sig_a, {(NW-SIGW-1){1'b0}}};
            end else begin
                rem_q <= RW'(sig_a);
                rad_q <= '0;
            end
        end else if (step) begin
            q_q   <= {q_q[QW-2:0], ge};
            rem_q <= op_q ? kept : (kept << 1);
            rad_q <= rad_q << 2;
        end
    end

    assign q      = q_q;
    assign rem_nz = |rem_q;
endmodule

// File: rtl/mf_round_pack.sv
// Normalizes the raw quotient/root bits and rounds them to nearest
// with guard/round/sticky. Handles the carry out of rounding,
// saturation on overflow and flush to zero on underflow.
// Assumes q has its leading one in bit QW-1 or QW-2.
module mf_round_pack
    import mf_pkg::*;
(
    input  logic                  sign,
    input  logic signed [EXW-1:0] exp_in,
    input  logic [QW-1:0]         q,
    input  logic                  sticky,
    output word_t                 res
);
    localparam logic signed [EXW-1:0] ONE  = EXW'(1);
    localparam logic signed [EXW-1:0] EMAX = EXW'(MAXE);

    logic [MW-1:0]         frac, frac_r;
    logic [MW:0]           sum;
    logic                  g, r, s, rup;
    logic signed [EXW-1:0] e, e_r;

    // Pick the kept bits, round, and pack or clamp.
    always_comb begin
        if (q[QW-1]) begin
            frac = q[QW-2 -: MW];
            g    = q[QW-2-MW];
            r    = q[QW-3-MW];
            s    = sticky | q[0];
            e    = exp_in;
        end else begin
            frac = q[QW-3 -: MW];
            g    = q[QW-3-MW];
            r    = q[QW-4-MW];
            s    = sticky;
            e    = exp_in - ONE;
        end
        rup = g & (r | s | frac[0]);
        sum = {1'b0, frac} + (MW+1)'(rup);
        if (sum[MW]) begin
            frac_r = '0;
            e_r    = e + ONE;
        end else begin
            frac_r = sum[MW-1:0];
            e_r    = e;
        end
        if (e_r > EMAX)
            res = {sign, {(EW+MW){1'b1}}};
        else if (e_r < ONE)
            res = {sign, {(EW+MW){1'b0}}};
        else
            res = {sign, e_r[EW-1:0], frac_r};
    end
endmodule

// File: rtl/mf_divsqrt.sv
// Top of the multi-cycle minifloat divide / square-root unit.
// Decodes operands, settles zero and invalid cases at once, and
// otherwise runs the shared engine for QW steps before packing.
// Assumes start is a single-cycle request. Start while busy is dropped.
module mf_divsqrt
    import mf_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         op_sqrt,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] result
);
    localparam logic signed [EXW-1:0] BIAS_X = EXW'(BIAS);

    logic                  busy_q, done_q, sign_q;
    logic [CW-1:0]         cnt_q;
    logic signed [EXW-1:0] exp_q;
    word_t                 res_q, packed_w, spec_val;

    logic                  sa, sb, a_zero, b_zero, special;
    logic [EW-1:0]         ea, eb;
    logic [SIGW-1:0]       ma, mb;
    logic [SIGW:0]         sig_a;
    logic signed [EXW-1:0] ea_s, eb_s, u_s, u_even, e_div, e_sqrt;
    logic                  load, step;
    logic [QW-1:0]         q_raw;
    logic                  rem_nz;

    // Unpack the operands and compute exponent and special outcomes.
    always_comb begin
        sa     = a[W-1];
        sb     = b[W-1];
        ea     = a[W-2 -: EW];
        eb     = b[W-2 -: EW];
        ma     = {1'b1, a[MW-1:0]};
        mb     = {1'b1, b[MW-1:0]};
        a_zero = (ea == '0);
        b_zero = (eb == '0);
        ea_s   = $signed({{(EXW-EW){1'b0}}, ea});
        eb_s   = $signed({{(EXW-EW){1'b0}}, eb});
        u_s    = ea_s - BIAS_X;
        u_even = u_s - $signed({{(EXW-1){1'b0}}, u_s[0]});
        e_div  = ea_s - eb_s + BIAS_X;
        e_sqrt = (u_even >>> 1) + BIAS_X;
        sig_a  = (op_sqrt && u_s[0]) ? {ma, 1'b0} : {1'b0, ma};
        special  = 1'b1;
        spec_val = '0;
        if (!op_sqrt) begin
            if (b_zero)      spec_val = '1;
            else if (a_zero) spec_val = {sa ^ sb, {(W-1){1'b0}}};
            else             special  = 1'b0;
        end else begin
            if (a_zero)      spec_val = {sa, {(W-1){1'b0}}};
            else if (sa)     spec_val = '1;
            else             special  = 1'b0;
        end
    end

    assign load = !busy_q && start && !special;
    assign step = busy_q && (cnt_q != '0);

    mf_iter_core u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .step    (step),
        .op_sqrt (op_sqrt),
        .sig_a   (sig_a),
        .sig_b   (mb),
        .q       (q_raw),
        .rem_nz  (rem_nz)
    );

    mf_round_pack u_pack (
        .sign   (sign_q),
        .exp_in (exp_q),
        .q      (q_raw),
        .sticky (rem_nz),
        .res    (packed_w)
    );

    // Accept requests, count steps and publish the result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            sign_q <= 1'b0;
            cnt_q  <= '0;
            exp_q  <= '0;
            res_q  <= '0;
        end else begin
            done_q <= 1'b0;
            if (!busy_q) begin
                if (start) begin
                    if (special) begin
                        res_q  <= spec_val;
                        done_q <= 1'b1;
                    end else begin
                        busy_q <= 1'b1;
                        cnt_q  <= CW'(QW);
                        sign_q <= op_sqrt ? 1'b0 : (sa ^ sb);
                        exp_q  <= op_sqrt ? e_sqrt : e_div;
                    end
                end
            end else if (cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end else begin
                busy_q <= 1'b0;
                done_q <= 1'b1;
                res_q  <= packed_w;
            end
        end
    end

    assign busy   = busy_q;
    assign done   = done_q;
    assign result = res_q;
endmodule

// File: rtl/mf_divsqrt_chk.sv
// Port-level checker for mf_divsqrt, attached by bind.
// Tracks the accepted operation and the cycles since acceptance.
module mf_divsqrt_chk
    import mf_pkg::*;
(
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         op_sqrt,
    input logic [W-1:0] a,
    input logic [W-1:0] b,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] result
);
    logic       op_seen;
    logic [4:0] lat_q;

    // Record the operation and count cycles since it was accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_seen <= 1'b0;
            lat_q   <= '0;
        end else if (start && !busy) begin
            op_seen <= op_sqrt;
            lat_q   <= 5'd1;
        end else if (lat_q != '0 && lat_q != 5'd31) begin
            lat_q <= lat_q + 5'd1;
        end
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                                   // R11
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !done ##1 !done |-> $stable(result));                              // R11
    AST_BUSY_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));                                                  // R9
    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy || done));                                          // R10
    AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (lat_q == 5'd1 || lat_q == 5'(QW + 2)));                  // R9
    AST_SQRT_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_seen) |-> (!result[W-1] || result[W-2:0] == '0 || result == '1)); // R3
endmodule

bind mf_divsqrt mf_divsqrt_chk u_chk (.*);

// File: tb/mf_divsqrt_test.sv
`timescale 1ns/1ps
module mf_divsqrt_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       op_sqrt = 1'b0;
    logic [7:0] a = '0, b = '0;
    logic       busy, done;
    logic [7:0] result;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    mf_divsqrt uut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_sqrt(op_sqrt),
        .a(a), .b(b), .busy(busy), .done(done), .result(result)
    );

    // {category, op_sqrt, a, b, expected}. Category: 0 R1, 1 R2, 2 R3, 3 R4,
    // 4 R5, 5 R6, 6 R7, 7 R8. Categories 0, 6 and 7 complete without the loop.
    localparam int NV = 23;
    localparam logic [27:0] VEC [NV] = '{
        {3'd1, 1'b0, 8'h40, 8'h30, 8'h40},
        {3'd1, 1'b0, 8'hB0, 8'h40, 8'hA0},
        {3'd1, 1'b0, 8'h30, 8'h48, 8'h15},
        {3'd3, 1'b0, 8'h30, 8'h34, 8'h2A},
        {3'd2, 1'b1, 8'h50, 8'h00, 8'h40},
        {3'd2, 1'b1, 8'h62, 8'h00, 8'h48},
        {3'd2, 1'b1, 8'h10, 8'h00, 8'h20},
        {3'd2, 1'b1, 8'h7F, 8'h00, 8'h56},
        {3'd3, 1'b1, 8'h40, 8'h00, 8'h37},
        {3'd3, 1'b1, 8'h20, 8'h00, 8'h27},
        {3'd4, 1'b0, 8'h70, 8'h10, 8'h7F},
        {3'd4, 1'b0, 8'hF0, 8'h10, 8'hFF},
        {3'd5, 1'b0, 8'h10, 8'h70, 8'h00},
        {3'd5, 1'b0, 8'h90, 8'h70, 8'h80},
        {3'd6, 1'b0, 8'h30, 8'h00, 8'hFF},
        {3'd6, 1'b0, 8'h00, 8'h00, 8'hFF},
        {3'd6, 1'b0, 8'h30, 8'h0A, 8'hFF},
        {3'd6, 1'b1, 8'hC0, 8'h00, 8'hFF},
        {3'd7, 1'b0, 8'h00, 8'h40, 8'h00},
        {3'd7, 1'b0, 8'h80, 8'h40, 8'h80},
        {3'd7, 1'b1, 8'h80, 8'h00, 8'h80},
        {3'd0, 1'b0, 8'h05, 8'hC0, 8'h80},
        {3'd0, 1'b1, 8'h05, 8'h00, 8'h00}
    };

    function automatic string tag(input logic [2:0] c);
        case (c)
            3'd0: return "R1";
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3: return "R4";
            3'd4: return "R5";
            3'd5: return "R6";
            3'd6: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
        end
    endtask

    // Issue one request; lat is the cycle index after acceptance where done is seen.
    task automatic run_op(input logic op, input logic [7:0] xa, input logic [7:0] xb,
                          output int lat, output logic busy1);
        @(negedge clk);
        start = 1'b1; op_sqrt = op; a = xa; b = xb;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        busy1 = busy;
        while (!done && lat < 40) begin
            @(negedge clk);
            lat++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        int   lat;
        logic b1;
        logic [7:0] held;
        repeat (3) @(negedge clk);
        // R12: reset state
        chk(busy == 1'b0 && done == 1'b0 && result == 8'h00, "R12", "reset outputs",
            {busy, done, result}, 0);
        rst_n = 1'b1;

        // Table walk: value, latency (R9) and busy flag (R9)
        for (int i = 0; i < NV; i++) begin
            logic [2:0] cat;
            bit sp;
            cat = VEC[i][27:25];
            sp  = (cat == 3'd0 || cat == 3'd6 || cat == 3'd7);
            run_op(VEC[i][24], VEC[i][23:16], VEC[i][15:8], lat, b1);
            chk(result == VEC[i][7:0], tag(cat), $sformatf("vector %0d result", i),
                result, VEC[i][7:0]);
            chk(lat == (sp ? 1 : 10), "R9", $sformatf("vector %0d done latency", i),
                lat, sp ? 1 : 10);
            chk(b1 == !sp, "R9", $sformatf("vector %0d busy after accept", i), b1, !sp);
        end

        // R10: a second start mid-operation is dropped
        @(negedge clk);
        start = 1'b1; op_sqrt = 1'b0; a = 8'h30; b = 8'h48;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        repeat (2) begin @(negedge clk); lat++; end
        start = 1'b1; op_sqrt = 1'b1; a = 8'h62; b = 8'h00;
        @(negedge clk); lat++;
        start = 1'b0;
        while (!done && lat < 40) begin @(negedge clk); lat++; end
        chk(result == 8'h15, "R10", "result of first request kept", result, 8'h15);
        chk(lat == 10, "R10", "latency unchanged by extra start", lat, 10);
        held = result;
        @(negedge clk);
        chk(done == 1'b0, "R11", "done lasts one cycle", done, 0);
        begin
            int extra = 0;
            for (int k = 0; k < 14; k++) begin
                @(negedge clk);
                if (done) extra++;
            end
            chk(extra == 0, "R10", "no done from dropped start", extra, 0);
        end
        chk(result == held, "R11", "result held after done", result, held);

        // R12: reset during a running operation
        @(negedge clk);
        start = 1'b1; op_sqrt = 1'b1; a = 8'h7F; b = 8'h00;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0 && result == 8'h00, "R12", "reset mid-operation",
            {busy, done, result}, 0);
        rst_n = 1'b1;
        repeat (12) @(negedge clk);
        chk(done == 1'b0 && result == 8'h00, "R12", "no completion after reset",
            {done, result}, 0);

        summary();
        $finish;
    end
endmodule